// File: doc/BRIEF.md
# Cascadable Serial Command Receiver

This block receives 16-bit command words over a four-wire serial link and turns each one into a single register-write request. The controller drives a serial clock, a data line and a latch strobe. The block shifts data in on each rising serial clock. When the strobe rises, it commits the word it holds as one write of a 4-bit address and an 8-bit value.

The block also drives a serial output for cascading. Each bit leaves the top of the 16-bit shift register and appears on that output at the next falling serial clock. The next device in the chain can then sample it on the following rising edge. To reach the Nth device, the controller shifts the wanted word, then shifts N-1 words that carry address zero, and then raises the strobe once for all devices. Address zero is a no-op, so the other devices do not write anything.

All three serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and the block detects their edges in the system clock domain. The write output follows valid-only semantics: `wr_valid` is high for exactly one system clock, and there is no back-pressure. The register file behind this block must accept every pulse in the cycle it appears.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset, `wr_valid` is 0 and `ser_dout` is 0, and the shift register contents are all zero.
- R2: A command word is 16 bits sent most significant bit first. Bits 11..8 form the write address and bits 7..0 form the write data. Bits 15..12 have no effect on the write.
- R3: `ser_din` is sampled only on a rising edge of `ser_clk`. Changes of `ser_din` while `ser_clk` is steady shift nothing.
- R4: A rising edge of `ser_load` commits the held word. `wr_valid` is then high for exactly one system clock, with `wr_addr` and `wr_data` valid in that cycle, and never without a preceding strobe edge.
- R5: If fewer than 16 rising `ser_clk` edges arrive between two strobe edges (or since reset), the strobe produces no write.
- R6: If more than 16 rising `ser_clk` edges arrive before the strobe, the write uses the last 16 bits received.
- R7: A committed word whose address bits 11..8 equal 0 produces no `wr_valid` pulse.
- R8: `ser_dout` changes only after a falling edge of `ser_clk`. After the falling edge that follows the Kth rising edge, it carries the bit sampled at rising edge K-15. Before 16 bits have been shifted, it carries 0. The strobe does not clear the shift register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Latch strobe; rising edge commits the word |
| ser_dout | output | 1 | Cascade data out, updated after falling serial clock |
| wr_valid | output | 1 | One-cycle register write request |
| wr_addr | output | 4 | Write address (word bits 11..8) |
| wr_data | output | 8 | Write data (word bits 7..0) |

## Verification
The hardest case to reach from the ports is a strobe that arrives after a bit count other than 16. Two such cases matter: a short burst that must be dropped, and an overlong burst where only the trailing 16 bits count. The driver task takes an explicit bit count, so the bench sends 8-bit and 20-bit bursts between ordinary words. It also sends a 32-bit burst of a real word followed by a no-op word, which walks the real word through the cascade output. The bench tracks its own copy of the last 16 bits shifted and compares `ser_dout` before every rising edge, so the half-cycle chaining delay is checked across strobes and bursts of every length.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
  localparam int PKT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_LSB = DATA_W;
  localparam int CNT_W  = $clog2(PKT_W + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/cdc_sync.sv
module cdc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cmd_shifter.sv
module cmd_shifter
  import serial_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  input  logic             out_en,
  input  logic             clr_cnt,
  output logic [PKT_W-1:0] word,
  output logic             full,
  output logic             dout
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
      dout <= 1'b0;
    end else begin
      if (shift_en) word <= {word[PKT_W-2:0], din};
      if (clr_cnt) cnt <= '0;
      else if (shift_en && cnt != CNT_W'(PKT_W)) cnt <= cnt + 1'b1;
      if (out_en) dout <= word[PKT_W-1];
    end
  end

  assign full = (cnt == CNT_W'(PKT_W));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PKT_W));

  p_dout_only_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> $stable(dout));
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import serial_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             full,
  input  logic [PKT_W-1:0] word,
  output logic             wr_valid,
  output wr_cmd_t          cmd
);
  logic [ADDR_W-1:0] addr_f;

  assign addr_f = word[ADDR_LSB +: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      cmd      <= '0;
    end else begin
      wr_valid <= commit && full && (addr_f != '0);
      if (commit) begin
        cmd.addr <= addr_f;
        cmd.data <= word[DATA_W-1:0];
      end
    end
  end

  p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_load,
  output logic              ser_dout,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0] pins_s;
  logic       sclk_q, load_q;
  logic       sclk_rise, sclk_fall, load_rise;
  logic [PKT_W-1:0] word;
  logic       full;
  wr_cmd_t    cmd;

  cdc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_load, ser_din, ser_clk}),
    .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      sclk_q <= pins_s[0];
      load_q <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[0] & ~sclk_q;
  assign sclk_fall = ~pins_s[0] & sclk_q;
  assign load_rise = pins_s[2] & ~load_q;

  cmd_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .din(pins_s[1]),
    .out_en(sclk_fall), .clr_cnt(load_rise),
    .word(word), .full(full), .dout(ser_dout)
  );

  cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n),
    .commit(load_rise), .full(full), .word(word),
    .wr_valid(wr_valid), .cmd(cmd)
  );

  assign wr_addr = cmd.addr;
  assign wr_data = cmd.data;

  p_noop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr != '0);

  p_write_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(load_rise));
endmodule

// File: tb/serial_cmd_rx_tb.sv
`timescale 1ns/1ps
module serial_cmd_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_load = 1'b0;
  logic ser_dout, wr_valid;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] model = '0;
  int nbits = 0;
  logic [11:0] expq [$];

  localparam time HALF = 56ns;

  always #4ns clk = ~clk;

  serial_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_load(ser_load), .ser_dout(ser_dout), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // R3 R8: bits shift on rising serial clock; dout checked before each rise
  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n-1; i >= 0; i--) begin
      ser_din = v[i];
      #(HALF/2);
      ser_din = ~v[i];  // R3: toggling while clock is low must not shift
      #(HALF/4);
      ser_din = v[i];
      #(HALF/4);
      chk(ser_dout === model[15], "R8 dout", ser_dout, model[15]);
      ser_clk = 1'b1;
      model = {model[14:0], v[i]};
      if (nbits < 16) nbits++;
      #HALF;
      ser_clk = 1'b0;
    end
    #HALF;
  endtask

  // R4 R5 R7: strobe; expected write pushed into scoreboard
  task automatic strobe();
    if (nbits >= 16 && model[11:8] != 4'h0) expq.push_back(model[11:0]);
    ser_load = 1'b1;
    #HALF;
    ser_load = 1'b0;
    #HALF;
    nbits = 0;
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R5/R7 unexpected write", {wr_addr, wr_data}, 0);
      end else begin
        logic [11:0] e;
        e = expq.pop_front();
        chk({wr_addr, wr_data} === e, "R2/R4/R6 write", {wr_addr, wr_data}, e);
      end
    end
  end

  // R4: one-cycle pulse width
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_v && wr_valid) chk(1'b0, "R4 pulse width", 2, 1);
    prev_v <= wr_valid;
  end

  initial begin
    #20ns;
    rst_n = 1'b1;
    #40ns;
    chk(wr_valid === 1'b0, "R1 valid", wr_valid, 0);
    chk(ser_dout === 1'b0, "R1 dout", ser_dout, 0);
    strobe();                         // R5: no bits yet
    send_bits(32'h0000_A35C, 16);     // R2: plain write
    strobe();
    send_bits(32'h0000_F1FF, 16);     // R2: top nibble ignored
    strobe();
    send_bits(32'h0000_0077, 16);     // R7: no-op
    strobe();
    send_bits(32'h0000_00C5, 8);      // R5: short burst dropped
    strobe();
    send_bits(32'h000B_4E21, 20);     // R6: last 16 bits = 0x4E21
    strobe();
    send_bits(32'h5842_0000, 32);     // R8: chained word then no-op
    strobe();
    send_bits(32'h0000_0890, 16);     // R8: dout carries 0x0000 then word
    strobe();
    send_bits(32'h0000_0F00, 15);     // R5: 15 bits only
    strobe();
    #200ns;
    chk(expq.size() == 0, "R4 pending writes", expq.size(), 0);
    chk(wr_valid === 1'b0, "R4 idle", wr_valid, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000ns;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule